// File: doc/BRIEF.md
# Three-Gain Range Selector

The block receives one sample of a detector signal that has been digitized three times in parallel: through a high-gain path (gain 100), a medium-gain path (gain 10) and a low-gain path (gain 1). Each path delivers a 12-bit ADC code. The block keeps the most precise reading that is still trustworthy. It takes the highest-gain code whose value lies below a saturation threshold. It reports that raw code together with a 2-bit gain identifier. It also rescales the code onto one common scale, so that downstream logic sees a single number covering more than 16 bits of dynamic range.

The saturation threshold comes from an input. A zero on that input selects a built-in default of 3900. When the low-gain path is itself saturated, the block still delivers it and raises an out-of-range flag. All results are registered and appear one clock after the input strobe. The results then hold until the next strobe.

Top module: `gain_range_select`

## Requirements
- R1: A gain path counts as saturated when its code is greater than or equal to the effective threshold. A code one below the threshold is not saturated.
- R2: The effective threshold equals `thresh_i` when it is non-zero. When `thresh_i` is zero, the effective threshold is 3900.
- R3: The selection priority is high gain first, then medium, then low. The high path is taken whenever it is unsaturated. The medium path is taken only when high is saturated and medium is not. Otherwise the low path is taken.
- R4: `gain_o` encodes the chosen path as 2'b00 for high, 2'b01 for medium and 2'b10 for low. The value 2'b11 never appears.
- R5: `code_o` is the chosen raw code. `value_o` (19 bits) is that code multiplied by 1 for high, by 10 for medium and by 100 for low.
- R6: `over_o` is 1 exactly when the low path is chosen and the low code is saturated. Otherwise it is 0.
- R7: Results appear on the clock edge that samples `valid_i` high. `valid_o` is high for exactly that one following cycle per strobe.
- R8: While `valid_i` is low, `code_o`, `gain_o`, `value_o` and `over_o` keep their values, whatever the code inputs do.
- R9: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Strobe marking a new sample on the code inputs |
| hi_code_i | input | 12 | Code from the gain-100 path |
| mid_code_i | input | 12 | Code from the gain-10 path |
| lo_code_i | input | 12 | Code from the gain-1 path |
| thresh_i | input | 12 | Saturation threshold; zero selects 3900 |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| code_o | output | 12 | Selected raw code |
| gain_o | output | 2 | Selected gain path identifier |
| value_o | output | 19 | Code rescaled to the common scale |
| over_o | output | 1 | Low path chosen while saturated |

## Verification
The assertions check on every cycle that the strobe timing is correct and that the held results stay stable between strobes. They also check that an unsaturated high code always wins, that the gain code stays legal, that the flag only appears together with the low path, and that a high-gain result is passed through unscaled. Some behaviours can only be shown by the bench's directed scenarios against its own reference model:
- the exact boundary at the threshold, and the fallback to 3900;
- the medium and low scaling factors;
- the out-of-range case;
- the reset values.

// File: rtl/grs_pkg.sv
package grs_pkg;
  typedef enum logic [1:0] {
    GAIN_HI  = 2'b00,
    GAIN_MID = 2'b01,
    GAIN_LO  = 2'b10
  } gain_e;

  localparam int NUM_PATHS = 3;
endpackage

// File: rtl/grs_sat_detect.sv
module grs_sat_detect #(
  parameter int CODE_W = 12,
  parameter int NPATH  = 3
) (
  input  logic [NPATH-1:0][CODE_W-1:0] codes_i,
  input  logic [CODE_W-1:0]            limit_i,
  output logic [NPATH-1:0]             sat_o
);
  for (genvar p = 0; p < NPATH; p++) begin : g_cmp
    assign sat_o[p] = (codes_i[p] >= limit_i);
  end
endmodule

// File: rtl/grs_priority.sv
module grs_priority
  import grs_pkg::*;
(
  input  logic [NUM_PATHS-1:0] sat_i,
  output gain_e                pick_o,
  output logic                 clip_o
);
  always_comb begin
    if (!sat_i[0])      pick_o = GAIN_HI;
    else if (!sat_i[1]) pick_o = GAIN_MID;
    else                pick_o = GAIN_LO;
  end

  // the low path is only reached when high and medium are saturated
  assign clip_o = (pick_o == GAIN_LO) && sat_i[2];
endmodule

// File: rtl/grs_scaler.sv
module grs_scaler
  import grs_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int OUT_W    = 19,
  parameter int MID_MULT = 10,
  parameter int LO_MULT  = 100
) (
  input  logic [CODE_W-1:0] code_i,
  input  gain_e             gain_i,
  output logic [OUT_W-1:0]  value_o
);
  function automatic logic [OUT_W-1:0] rescale(input logic [CODE_W-1:0] c,
                                               input gain_e g);
    logic [OUT_W-1:0] wide;
    wide = OUT_W'(c);
    case (g)
      GAIN_HI:  rescale = wide;
      GAIN_MID: rescale = wide * OUT_W'(MID_MULT);
      default:  rescale = wide * OUT_W'(LO_MULT);
    endcase
  endfunction

  assign value_o = rescale(code_i, gain_i);
endmodule

// File: rtl/gain_range_select.sv
module gain_range_select
  import grs_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int OUT_W      = 19,
  parameter int MID_MULT   = 10,
  parameter int LO_MULT    = 100,
  parameter int DEF_THRESH = 3900
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] hi_code_i,
  input  logic [CODE_W-1:0] mid_code_i,
  input  logic [CODE_W-1:0] lo_code_i,
  input  logic [CODE_W-1:0] thresh_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        gain_o,
  output logic [OUT_W-1:0]  value_o,
  output logic              over_o
);
  localparam logic [CODE_W-1:0] DEF_LIMIT = CODE_W'(DEF_THRESH);

  logic [NUM_PATHS-1:0][CODE_W-1:0] lane_codes;
  logic [CODE_W-1:0]                thr_eff;
  logic [NUM_PATHS-1:0]             lane_sat;
  gain_e                            pick;
  logic                             clip;
  logic [CODE_W-1:0]                pick_code;
  logic [OUT_W-1:0]                 pick_value;

  assign lane_codes = {lo_code_i, mid_code_i, hi_code_i};
  assign thr_eff    = (thresh_i == '0) ? DEF_LIMIT : thresh_i;

  grs_sat_detect #(.CODE_W(CODE_W), .NPATH(NUM_PATHS)) u_sat (
    .codes_i (lane_codes),
    .limit_i (thr_eff),
    .sat_o   (lane_sat)
  );

  grs_priority u_pri (
    .sat_i  (lane_sat),
    .pick_o (pick),
    .clip_o (clip)
  );

  always_comb begin
    case (pick)
      GAIN_HI:  pick_code = hi_code_i;
      GAIN_MID: pick_code = mid_code_i;
      default:  pick_code = lo_code_i;
    endcase
  end

  grs_scaler #(
    .CODE_W(CODE_W), .OUT_W(OUT_W), .MID_MULT(MID_MULT), .LO_MULT(LO_MULT)
  ) u_scale (
    .code_i  (pick_code),
    .gain_i  (pick),
    .value_o (pick_value)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
      gain_o  <= '0;
      value_o <= '0;
      over_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        code_o  <= pick_code;
        gain_o  <= pick;
        value_o <= pick_value;
        over_o  <= clip;
      end
    end
  end
endmodule

// File: rtl/grs_checker.sv
module grs_checker #(
  parameter int CODE_W = 12,
  parameter int OUT_W  = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [CODE_W-1:0] hi_code_i,
  input logic [CODE_W-1:0] thr_eff,
  input logic              valid_o,
  input logic [CODE_W-1:0] code_o,
  input logic [1:0]        gain_o,
  input logic [OUT_W-1:0]  value_o,
  input logic              over_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(code_o) && $stable(gain_o) && $stable(value_o) && $stable(over_o))); // R8
  AST_HIGH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (hi_code_i < thr_eff)) |=> (gain_o == 2'b00)); // R3
  AST_GAIN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_o != 2'b11); // R4
  AST_OVER_LOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o |-> (gain_o == 2'b10)); // R6
  AST_HIGH_UNITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_o == 2'b00) |-> (value_o == OUT_W'(code_o))); // R5
endmodule

bind gain_range_select grs_checker #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_grs_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .hi_code_i (hi_code_i),
  .thr_eff   (thr_eff),
  .valid_o   (valid_o),
  .code_o    (code_o),
  .gain_o    (gain_o),
  .value_o   (value_o),
  .over_o    (over_o)
);

// File: tb/test_gain_range_select.sv
module test_gain_range_select;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [11:0] hi_c, mid_c, lo_c, thr;
  logic        valid_o;
  logic [11:0] code_o;
  logic [1:0]  gain_o;
  logic [18:0] value_o;
  logic        over_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  gain_range_select i_gain_range_select (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .hi_code_i(hi_c), .mid_code_i(mid_c), .lo_code_i(lo_c), .thresh_i(thr),
    .valid_o(valid_o), .code_o(code_o), .gain_o(gain_o),
    .value_o(value_o), .over_o(over_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference: effective limit, priority, scaling by shifts and adds
  task automatic model(input int h, input int m, input int l, input int t,
                       output int g, output int c, output int v, output int ov);
    int lim;
    lim = (t == 0) ? 3900 : t;
    if (h < lim)      begin g = 0; c = h; v = c; end
    else if (m < lim) begin g = 1; c = m; v = (c << 3) + (c << 1); end
    else              begin g = 2; c = l; v = (c << 6) + (c << 5) + (c << 2); end
    ov = (g == 2 && l >= lim) ? 1 : 0;
  endtask

  task automatic apply(input string req, input int h, input int m, input int l, input int t);
    int g, c, v, ov;
    model(h, m, l, t, g, c, v, ov);
    @(negedge clk);
    hi_c = 12'(h); mid_c = 12'(m); lo_c = 12'(l); thr = 12'(t); valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check("R7", "valid_o after strobe", int'(valid_o), 1);
    check(req, "gain_o", int'(gain_o), g);
    check(req, "code_o", int'(code_o), c);
    check(req, "value_o", int'(value_o), v);
    check(req, "over_o", int'(over_o), ov);
    @(negedge clk);
    check("R7", "valid_o one cycle later", int'(valid_o), 0);
  endtask

  task automatic t_reset();
    check("R9", "valid_o in reset", int'(valid_o), 0);
    check("R9", "code_o in reset", int'(code_o), 0);
    check("R9", "gain_o in reset", int'(gain_o), 0);
    check("R9", "value_o in reset", int'(value_o), 0);
    check("R9", "over_o in reset", int'(over_o), 0);
  endtask

  task automatic t_priority();
    apply("R3", 1234, 100, 10, 3900);     // high wins
    apply("R3", 4000, 2500, 250, 3900);   // medium chosen
    apply("R3", 4095, 3950, 3000, 3900);  // low chosen
    apply("R4", 4095, 4095, 0, 3900);     // low code zero
  endtask

  task automatic t_threshold_edge();
    apply("R1", 2999, 4095, 4095, 3000);  // one below: not saturated
    apply("R1", 3000, 2999, 4095, 3000);  // at limit: saturated
    apply("R1", 3000, 3000, 2999, 3000);  // both saturated, low clean
  endtask

  task automatic t_default_limit();
    apply("R2", 3899, 4095, 4095, 0);     // default 3900, just below
    apply("R2", 3900, 1000, 100, 0);      // default 3900, at limit
  endtask

  task automatic t_scaling();
    apply("R5", 4095, 4095, 4094, 4095); // low x100 near top of range
    apply("R5", 3950, 3899, 390, 0);      // medium x10
    apply("R5", 7, 70, 700, 0);           // high x1
  endtask

  task automatic t_over();
    apply("R6", 4095, 4095, 4095, 0);     // low saturated -> flag
    apply("R6", 4095, 4095, 3899, 0);     // low clean -> no flag
    apply("R6", 10, 4000, 4000, 0);       // low saturated but not chosen
  endtask

  task automatic t_hold();
    apply("R8", 4000, 1500, 150, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      hi_c = 12'(k * 11); mid_c = 12'(4095 - k); lo_c = 12'(4095); thr = 12'(k + 1);
    end
    @(negedge clk);
    check("R8", "gain held", int'(gain_o), 1);
    check("R8", "code held", int'(code_o), 1500);
    check("R8", "value held", int'(value_o), 15000);
    check("R8", "over held", int'(over_o), 0);
    check("R8", "valid_o stays low", int'(valid_o), 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R7 watchdog: actual %0d expected %0d cycles", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0;
    hi_c = '0; mid_c = '0; lo_c = '0; thr = '0;
    repeat (3) @(negedge clk);
    valid_i = 1'b1; hi_c = 12'd5;
    @(negedge clk);
    valid_i = 1'b0;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_threshold_edge();
    t_default_limit();
    t_scaling();
    t_over();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule